// File: doc/BRIEF.md
# Read-after-write hazard control for a five-stage in-order pipeline

This unit resolves read-after-write data hazards in a classic in-order pipeline with fetch, decode, execute, memory and writeback stages. The surrounding core gives it the register numbers and write controls of the instruction in decode. The unit keeps its own copy of these tags as the instruction moves through execute, memory and writeback. From that copy it steers the two execute-stage operand multiplexers. The first operand feeds the ALU. The second feeds the ALU or, for a store, supplies the store data. Each multiplexer can pick the value read from the register file, the result held after execute, or the result held after memory.

When a load is followed at once by an instruction that reads the loaded register, forwarding cannot help, because the value does not exist yet. The unit then freezes the program counter and the decode register for one cycle and sends a bubble into execute. The unit also makes the register file behave as write-then-read in a single cycle: a decode-stage read of the register that writeback is writing returns the value being written. A mode input turns forwarding off. In that mode the unit stalls decode until the producer has reached writeback, so the same programs still run correctly, only more slowly.

Top module: `raw_hazard_unit`

## Requirements
- R1: When the execute-stage source register is non-zero and matches the destination of a register-writing instruction in the memory stage, the operand select is 2'b01 and the operand equals `mem_result`.
- R2: When only the writeback-stage instruction writes the matching non-zero register, the select is 2'b10 and the operand equals `wb_result`. When no producer matches, the select is 2'b00 and the operand equals the value read in decode.
- R3: When both the memory-stage and the writeback-stage producers match, the younger memory-stage value wins (select 2'b01).
- R4: Register 0 never forwards and never stalls. A producer whose write enable is low never forwards and never stalls.
- R5: With forwarding on, a load in execute whose destination matches a source of the decode instruction raises `hold_front` and `squash_idex` for exactly one cycle. The consumer then receives the loaded value from writeback.
- R6: A decode-stage read of a non-zero register that writeback is writing in the same cycle returns `wb_result` instead of the register-file value.
- R7: With `fwd_en` low, both selects stay 2'b00. Decode stalls while any source matches a writing instruction in execute or memory.
- R8: The sequence sub, and, or, add, sw, with all four later instructions reading the sub result, finishes writeback of the store in cycle 9 with forwarding (no stalls). Without forwarding it finishes in cycle 11 (two stalls).
- R9: The same sequence headed by a load finishes in cycle 10 with forwarding (one stall).
- R10: The store-data operand (second operand) follows the same forwarding rules as an ALU operand.
- R11: After reset, the execute, memory and writeback tags are empty. There is no stall, both selects are 2'b00, and decode reads pass straight through.
- R12: The bubble sent into execute during a stall carries no write enable, so it can neither forward nor stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1: bypass paths in use; 0: stall until writeback |
| id_src_a | input | AW | First source register of the decode instruction (0 when unused) |
| id_src_b | input | AW | Second source register of the decode instruction (0 when unused) |
| id_dst | input | AW | Destination register of the decode instruction |
| id_wen | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| rf_rd_a | input | DW | Register-file read value for id_src_a |
| rf_rd_b | input | DW | Register-file read value for id_src_b |
| ex_val_a | input | DW | First operand latched into the execute stage |
| ex_val_b | input | DW | Second operand latched into the execute stage |
| mem_result | input | DW | Result held in the execute-to-memory register |
| wb_result | input | DW | Value being written back (ALU result or load data) |
| id_opnd_a | output | DW | First decode operand after write-through |
| id_opnd_b | output | DW | Second decode operand after write-through |
| ex_opnd_a | output | DW | First execute operand after bypass |
| ex_opnd_b | output | DW | Second execute operand (ALU input or store data) after bypass |
| fwd_sel_a | output | 2 | First operand select: 00 register, 01 memory stage, 10 writeback |
| fwd_sel_b | output | 2 | Second operand select, same encoding |
| hold_front | output | 1 | Hold the program counter and the decode register |
| squash_idex | output | 1 | Clear the controls entering execute |

## Verification
The bench runs short programs through a cycle-accurate pipeline model built around the unit. It compares the final registers and data memory with a sequential interpreter, and it checks the writeback cycle of the last instruction and the number of stall cycles. Several cases are aimed at likely mistakes. A double producer of the same register catches an older-value-wins priority bug, which leaves a stale result in the register that depends on it. A load into register 0, followed by readers of register 0, catches a design that forwards or stalls on register 0: a wrong register value or one extra cycle. A load feeding the second operand, followed by a store that needs both write-through and a forwarded store datum, shows a missing bubble, a repeated stall or a missing write-through as a wrong memory word or a wrong cycle count. The forwarding-off run must show exactly two stalls and an eleven-cycle finish.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source chosen for an execute-stage operand
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,   // value latched from decode
    FWD_EXM = 2'b01,   // result sitting after execute
    FWD_MWB = 2'b10    // value being written back
  } fwd_sel_e;

  localparam int NOPS = 2;  // operands per instruction

endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hzd_stage_track.sv
// Shadow of the register tags as an instruction moves from decode to writeback.
module hzd_stage_track #(
  parameter int AW = 5,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          squash,
  input  logic [AW-1:0] id_src [NS],
  input  logic [AW-1:0] id_dst,
  input  logic          id_wen,
  input  logic          id_load,
  output logic [AW-1:0] ex_src [NS],
  output logic [AW-1:0] ex_dst,
  output logic          ex_wen,
  output logic          ex_load,
  output logic [AW-1:0] mem_dst,
  output logic          mem_wen,
  output logic [AW-1:0] wb_dst,
  output logic          wb_wen
);

  logic [AW-1:0] ex_src_q [NS];
  logic [AW-1:0] ex_src_d [NS];
  logic [AW-1:0] ex_dst_q, ex_dst_d;
  logic          ex_wen_q, ex_wen_d;
  logic          ex_load_q, ex_load_d;
  logic [AW-1:0] mem_dst_q, mem_dst_d;
  logic          mem_wen_q, mem_wen_d;
  logic [AW-1:0] wb_dst_q, wb_dst_d;
  logic          wb_wen_q, wb_wen_d;
  logic          adv_en;

  // the tag pipeline moves every cycle; a stall only swaps in a bubble
  assign adv_en = 1'b1;

  // next-state: decode -> execute (or bubble), execute -> memory -> writeback
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      ex_src_d[i] = squash ? '0 : id_src[i];
    end
    ex_dst_d  = squash ? '0   : id_dst;
    ex_wen_d  = squash ? 1'b0 : id_wen;
    ex_load_d = squash ? 1'b0 : id_load;
    mem_dst_d = ex_dst_q;
    mem_wen_d = ex_wen_q;
    wb_dst_d  = mem_dst_q;
    wb_wen_d  = mem_wen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) ex_src_q[i] <= '0;
      ex_dst_q  <= '0;
      ex_wen_q  <= 1'b0;
      ex_load_q <= 1'b0;
      mem_dst_q <= '0;
      mem_wen_q <= 1'b0;
      wb_dst_q  <= '0;
      wb_wen_q  <= 1'b0;
    end else if (adv_en) begin
      for (int i = 0; i < NS; i++) ex_src_q[i] <= ex_src_d[i];
      ex_dst_q  <= ex_dst_d;
      ex_wen_q  <= ex_wen_d;
      ex_load_q <= ex_load_d;
      mem_dst_q <= mem_dst_d;
      mem_wen_q <= mem_wen_d;
      wb_dst_q  <= wb_dst_d;
      wb_wen_q  <= wb_wen_d;
    end
  end

  assign ex_src  = ex_src_q;
  assign ex_dst  = ex_dst_q;
  assign ex_wen  = ex_wen_q;
  assign ex_load = ex_load_q;
  assign mem_dst = mem_dst_q;
  assign mem_wen = mem_wen_q;
  assign wb_dst  = wb_dst_q;
  assign wb_wen  = wb_wen_q;

endmodule

// File: rtl/hzd_fwd_pick.sv
// Bypass select and multiplexer for one execute-stage operand.
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] ex_src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output fwd_sel_e      sel,
  output logic [DW-1:0] opnd
);

  logic src_live, hit_mem, hit_wb;

  assign src_live = fwd_en && (ex_src != '0);
  assign hit_mem  = src_live && mem_wen && (mem_dst == ex_src);
  assign hit_wb   = src_live && wb_wen  && (wb_dst  == ex_src);

  // the memory-stage producer is younger and takes priority
  always_comb begin
    if (hit_mem)     sel = FWD_EXM;
    else if (hit_wb) sel = FWD_MWB;
    else             sel = FWD_RF;
  end

  always_comb begin
    unique case (sel)
      FWD_EXM: opnd = mem_val;
      FWD_MWB: opnd = wb_val;
      default: opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/hzd_luse_detect.sv
// Decides when decode must wait: load-use with bypass, any pending writer without.
module hzd_luse_detect #(
  parameter int AW = 5,
  parameter int NS = 2
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] id_src [NS],
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  output logic          stall
);

  logic [NS-1:0] hit_ex, hit_mem;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_src
      assign hit_ex[gi]  = (id_src[gi] != '0) && ex_wen  && (ex_dst  == id_src[gi]);
      assign hit_mem[gi] = (id_src[gi] != '0) && mem_wen && (mem_dst == id_src[gi]);
    end
  endgenerate

  always_comb begin
    if (fwd_en) stall = ex_load && (|hit_ex);
    else        stall = (|hit_ex) || (|hit_mem);
  end

endmodule

// File: rtl/hzd_wt_read.sv
// Write-through on one register-file read port.
module hzd_wt_read #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] id_src,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] opnd
);

  logic same_reg;

  assign same_reg = wb_wen && (id_src != '0) && (wb_dst == id_src);
  assign opnd     = same_reg ? wb_val : rf_val;

endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit
  import hzd_pkg::*;
#(
  parameter int AW         = 5,
  parameter int DW         = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] id_dst,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic [DW-1:0] rf_rd_a,
  input  logic [DW-1:0] rf_rd_b,
  input  logic [DW-1:0] ex_val_a,
  input  logic [DW-1:0] ex_val_b,
  input  logic [DW-1:0] mem_result,
  input  logic [DW-1:0] wb_result,
  output logic [DW-1:0] id_opnd_a,
  output logic [DW-1:0] id_opnd_b,
  output logic [DW-1:0] ex_opnd_a,
  output logic [DW-1:0] ex_opnd_b,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          hold_front,
  output logic          squash_idex
);

  logic          rst_q_n;
  logic          stall_w;
  logic [AW-1:0] id_src_w  [NOPS];
  logic [AW-1:0] ex_src_w  [NOPS];
  logic [DW-1:0] rf_id_w   [NOPS];
  logic [DW-1:0] opnd_id_w [NOPS];
  logic [DW-1:0] ex_val_w  [NOPS];
  logic [DW-1:0] opnd_ex_w [NOPS];
  fwd_sel_e      sel_w     [NOPS];
  logic [AW-1:0] ex_dst_w, mem_dst_w, wb_dst_w;
  logic          ex_wen_w, ex_load_w, mem_wen_w, wb_wen_w;

  assign id_src_w[0] = id_src_a;
  assign id_src_w[1] = id_src_b;
  assign rf_id_w[0]  = rf_rd_a;
  assign rf_id_w[1]  = rf_rd_b;
  assign ex_val_w[0] = ex_val_a;
  assign ex_val_w[1] = ex_val_b;

  hzd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  hzd_stage_track #(.AW(AW), .NS(NOPS)) u_track (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .squash  (stall_w),
    .id_src  (id_src_w),
    .id_dst  (id_dst),
    .id_wen  (id_wen),
    .id_load (id_load),
    .ex_src  (ex_src_w),
    .ex_dst  (ex_dst_w),
    .ex_wen  (ex_wen_w),
    .ex_load (ex_load_w),
    .mem_dst (mem_dst_w),
    .mem_wen (mem_wen_w),
    .wb_dst  (wb_dst_w),
    .wb_wen  (wb_wen_w)
  );

  hzd_luse_detect #(.AW(AW), .NS(NOPS)) u_luse (
    .fwd_en  (fwd_en),
    .id_src  (id_src_w),
    .ex_dst  (ex_dst_w),
    .ex_wen  (ex_wen_w),
    .ex_load (ex_load_w),
    .mem_dst (mem_dst_w),
    .mem_wen (mem_wen_w),
    .stall   (stall_w)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NOPS; gi++) begin : g_opnd
      hzd_fwd_pick #(.AW(AW), .DW(DW)) u_pick (
        .fwd_en  (fwd_en),
        .ex_src  (ex_src_w[gi]),
        .mem_dst (mem_dst_w),
        .mem_wen (mem_wen_w),
        .wb_dst  (wb_dst_w),
        .wb_wen  (wb_wen_w),
        .rf_val  (ex_val_w[gi]),
        .mem_val (mem_result),
        .wb_val  (wb_result),
        .sel     (sel_w[gi]),
        .opnd    (opnd_ex_w[gi])
      );

      hzd_wt_read #(.AW(AW), .DW(DW)) u_wt (
        .id_src (id_src_w[gi]),
        .wb_dst (wb_dst_w),
        .wb_wen (wb_wen_w),
        .rf_val (rf_id_w[gi]),
        .wb_val (wb_result),
        .opnd   (opnd_id_w[gi])
      );
    end
  endgenerate

  assign id_opnd_a   = opnd_id_w[0];
  assign id_opnd_b   = opnd_id_w[1];
  assign ex_opnd_a   = opnd_ex_w[0];
  assign ex_opnd_b   = opnd_ex_w[1];
  assign fwd_sel_a   = sel_w[0];
  assign fwd_sel_b   = sel_w[1];
  assign hold_front  = stall_w;
  assign squash_idex = stall_w;

endmodule

// File: rtl/raw_hazard_unit_chk.sv
module raw_hazard_unit_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_en,
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic          hold_front,
  input logic          squash_idex,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic [DW-1:0] ex_opnd_a,
  input logic [DW-1:0] ex_opnd_b,
  input logic [DW-1:0] mem_result,
  input logic [DW-1:0] wb_result,
  input logic [DW-1:0] id_opnd_a,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wen,
  input logic          ex_wen
);

  AST_EXM_VALUE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a == 2'b01) |-> (ex_opnd_a == mem_result)); // R1

  AST_MWB_VALUE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a == 2'b10) |-> (ex_opnd_a == wb_result)); // R2

  AST_STORE_DATA_EXM: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_b == 2'b01) |-> (ex_opnd_b == mem_result)); // R10

  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0) |-> !hold_front); // R4

  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && hold_front) |=> (!hold_front || !fwd_en)); // R5

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_dst != '0 && id_src_a == wb_dst) |-> (id_opnd_a == wb_result)); // R6

  AST_NOFWD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00)); // R7

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    squash_idex |=> !ex_wen); // R12

endmodule

bind raw_hazard_unit raw_hazard_unit_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fwd_en      (fwd_en),
  .id_src_a    (id_src_a),
  .id_src_b    (id_src_b),
  .hold_front  (hold_front),
  .squash_idex (squash_idex),
  .fwd_sel_a   (fwd_sel_a),
  .fwd_sel_b   (fwd_sel_b),
  .ex_opnd_a   (ex_opnd_a),
  .ex_opnd_b   (ex_opnd_b),
  .mem_result  (mem_result),
  .wb_result   (wb_result),
  .id_opnd_a   (id_opnd_a),
  .wb_dst      (wb_dst_w),
  .wb_wen      (wb_wen_w),
  .ex_wen      (ex_wen_w)
);

// File: tb/raw_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module raw_hazard_unit_tb_top;

  localparam int AW = 5, DW = 32, NR = 32, IMAX = 8, DM = 64, LIM = 40;
  localparam int OP_NOP = 0, OP_ADD = 1, OP_SUB = 2, OP_AND = 3, OP_OR = 4, OP_LW = 5, OP_SW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n, fwd_en, id_wen, id_load;
  logic [AW-1:0] id_src_a, id_src_b, id_dst;
  logic [DW-1:0] rf_rd_a, rf_rd_b, ex_val_a, ex_val_b, mem_result, wb_result;
  logic [DW-1:0] id_opnd_a, id_opnd_b, ex_opnd_a, ex_opnd_b;
  logic [1:0]    fwd_sel_a, fwd_sel_b;
  logic          hold_front, squash_idex;

  raw_hazard_unit #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .id_wen(id_wen), .id_load(id_load),
    .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b),
    .ex_val_a(ex_val_a), .ex_val_b(ex_val_b),
    .mem_result(mem_result), .wb_result(wb_result),
    .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b),
    .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .hold_front(hold_front), .squash_idex(squash_idex)
  );

  int n_chk = 0, n_bad = 0;

  int            p_op [IMAX], p_rs [IMAX], p_rt [IMAX], p_rd [IMAX];
  logic [DW-1:0] p_imm [IMAX];
  int            p_n;
  logic [DW-1:0] rf [NR], ref_rf [NR];
  logic [DW-1:0] dm [DM], ref_dm [DM];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_rtype(input int op);
    return (op >= OP_ADD) && (op <= OP_OR);
  endfunction

  function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] x, input logic [DW-1:0] y);
    case (op)
      OP_SUB: return x - y;
      OP_AND: return x & y;
      OP_OR:  return x | y;
      default: return x + y;
    endcase
  endfunction

  task automatic put(input int idx, input int op, input int rs, input int rt, input int rd, input int imm);
    p_op[idx] = op; p_rs[idx] = rs; p_rt[idx] = rt; p_rd[idx] = rd; p_imm[idx] = imm;
  endtask

  task automatic init_state();
    for (int i = 0; i < NR; i++) begin
      rf[i] = (i == 0) ? '0 : DW'(i * 3 + 1);
      ref_rf[i] = rf[i];
    end
    for (int i = 0; i < DM; i++) begin
      dm[i] = DW'(1000 + i);
      ref_dm[i] = dm[i];
    end
  endtask

  // sequential reference: one instruction at a time
  task automatic ref_run();
    for (int k = 0; k < p_n; k++) begin
      logic [DW-1:0] a, b, ad;
      a  = ref_rf[p_rs[k]];
      b  = ref_rf[p_rt[k]];
      ad = a + p_imm[k];
      if (is_rtype(p_op[k]) && p_rd[k] != 0) ref_rf[p_rd[k]] = alu(p_op[k], a, b);
      if (p_op[k] == OP_LW && p_rt[k] != 0)  ref_rf[p_rt[k]] = ref_dm[ad[5:0]];
      if (p_op[k] == OP_SW)                  ref_dm[ad[5:0]] = b;
    end
  endtask

  task automatic drive_idle();
    id_src_a = '0; id_src_b = '0; id_dst = '0; id_wen = 1'b0; id_load = 1'b0;
    rf_rd_a = '0; rf_rd_b = '0; ex_val_a = '0; ex_val_b = '0;
    mem_result = '0; wb_result = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R11: reset state seen at the ports
  task automatic t_reset_state();
    fwd_en = 1'b1;
    do_reset();
    id_src_a = 5'd3; id_src_b = 5'd4; rf_rd_a = 32'h55; rf_rd_b = 32'h66;
    ex_val_a = 32'h11; ex_val_b = 32'h22; mem_result = 32'h77; wb_result = 32'h88;
    #1;
    check("R11", "hold after reset", hold_front, 0);
    check("R11", "squash after reset", squash_idex, 0);
    check("R11", "select a after reset", fwd_sel_a, 0);
    check("R11", "select b after reset", fwd_sel_b, 0);
    check("R11", "decode read a", id_opnd_a, 32'h55);
    check("R11", "execute operand b", ex_opnd_b, 32'h22);
  endtask

  // cycle-accurate five-stage model around the unit
  task automatic run_prog(input bit fwd, input int exp_cyc, input int exp_stl, input string req_c, input string req_s);
    int pc, cyc, stl, done_cyc;
    bit ifid_v, idex_v, exmem_v, memwb_v, stall;
    int ifid_i, idex_i, exmem_i, memwb_i;
    logic [DW-1:0] idex_va, idex_vb, exmem_res, exmem_sd, memwb_res;
    logic [DW-1:0] opa, opb, ida, idb;
    fwd_en = fwd;
    do_reset();
    init_state();
    ref_run();
    pc = 0; cyc = 0; stl = 0; done_cyc = -1;
    ifid_v = 0; idex_v = 0; exmem_v = 0; memwb_v = 0;
    ifid_i = 0; idex_i = 0; exmem_i = 0; memwb_i = 0;
    idex_va = '0; idex_vb = '0; exmem_res = '0; exmem_sd = '0; memwb_res = '0;
    while (done_cyc < 0 && cyc < LIM) begin
      cyc++;
      // drive the unit for this cycle
      if (ifid_v && p_op[ifid_i] != OP_NOP) begin
        int op;
        op = p_op[ifid_i];
        id_src_a = AW'(p_rs[ifid_i]);
        id_src_b = (is_rtype(op) || op == OP_SW) ? AW'(p_rt[ifid_i]) : '0;
        id_dst   = is_rtype(op) ? AW'(p_rd[ifid_i]) : (op == OP_LW ? AW'(p_rt[ifid_i]) : '0);
        id_wen   = is_rtype(op) || op == OP_LW;
        id_load  = op == OP_LW;
      end else begin
        id_src_a = '0; id_src_b = '0; id_dst = '0; id_wen = 1'b0; id_load = 1'b0;
      end
      rf_rd_a = rf[id_src_a]; rf_rd_b = rf[id_src_b];
      ex_val_a = idex_va; ex_val_b = idex_vb;
      mem_result = exmem_res; wb_result = memwb_res;
      #1;
      stall = hold_front;
      opa = ex_opnd_a; opb = ex_opnd_b; ida = id_opnd_a; idb = id_opnd_b;
      // writeback
      if (memwb_v) begin
        int op;
        op = p_op[memwb_i];
        if (is_rtype(op) && p_rd[memwb_i] != 0) rf[p_rd[memwb_i]] = memwb_res;
        if (op == OP_LW && p_rt[memwb_i] != 0)  rf[p_rt[memwb_i]] = memwb_res;
        if (memwb_i == p_n - 1) done_cyc = cyc;
      end
      // memory
      memwb_v = exmem_v; memwb_i = exmem_i; memwb_res = exmem_res;
      if (exmem_v && p_op[exmem_i] == OP_LW) memwb_res = dm[exmem_res[5:0]];
      if (exmem_v && p_op[exmem_i] == OP_SW) dm[exmem_res[5:0]] = exmem_sd;
      // execute
      exmem_v = idex_v; exmem_i = idex_i; exmem_sd = opb;
      if (idex_v) begin
        if (p_op[idex_i] == OP_LW || p_op[idex_i] == OP_SW) exmem_res = opa + p_imm[idex_i];
        else exmem_res = alu(p_op[idex_i], opa, opb);
      end else exmem_res = '0;
      // decode and fetch
      if (stall) begin
        idex_v = 0; stl++;
      end else begin
        idex_v = ifid_v; idex_i = ifid_i; idex_va = ida; idex_vb = idb;
        if (pc < p_n) begin ifid_v = 1; ifid_i = pc; pc++; end
        else ifid_v = 0;
      end
      @(negedge clk);
    end
    if (done_cyc < 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s program hung: actual %0d expected %0d", req_c, cyc, exp_cyc);
    end else begin
      check(req_c, "cycle of last writeback", done_cyc, exp_cyc);
    end
    check(req_s, "stall cycles", stl, exp_stl);
    for (int i = 0; i < NR; i++) check(req_c, $sformatf("register %0d", i), rf[i], ref_rf[i]);
    for (int i = 0; i < DM; i++) check(req_c, $sformatf("memory word %0d", i), dm[i], ref_dm[i]);
  endtask

  // R1 R2 R6 R8: sub-headed chain with bypass
  task automatic t_sub_chain_fwd();
    p_n = 5;
    put(0, OP_SUB, 1, 3, 2, 0);
    put(1, OP_AND, 2, 5, 12, 0);
    put(2, OP_OR,  6, 2, 13, 0);
    put(3, OP_ADD, 2, 2, 14, 0);
    put(4, OP_SW,  2, 15, 0, 4);
    run_prog(1'b1, 9, 0, "R8", "R1");
  endtask

  // R7 R8: same chain with bypass off
  task automatic t_sub_chain_nofwd();
    p_n = 5;
    put(0, OP_SUB, 1, 3, 2, 0);
    put(1, OP_AND, 2, 5, 12, 0);
    put(2, OP_OR,  6, 2, 13, 0);
    put(3, OP_ADD, 2, 2, 14, 0);
    put(4, OP_SW,  2, 15, 0, 4);
    run_prog(1'b0, 11, 2, "R8", "R7");
  endtask

  // R5 R9: load-headed chain
  task automatic t_load_chain();
    p_n = 5;
    put(0, OP_LW,  1, 2, 0, 20);
    put(1, OP_AND, 2, 5, 12, 0);
    put(2, OP_OR,  6, 2, 13, 0);
    put(3, OP_ADD, 2, 2, 14, 0);
    put(4, OP_SW,  2, 15, 0, 3);
    run_prog(1'b1, 10, 1, "R9", "R5");
  endtask

  // R3 R10: two writers of one register, then a forwarded store datum
  task automatic t_priority_store();
    p_n = 5;
    put(0, OP_ADD, 1, 1, 2, 0);
    put(1, OP_SUB, 3, 1, 2, 0);
    put(2, OP_OR,  2, 0, 9, 0);
    put(3, OP_ADD, 9, 9, 7, 0);
    put(4, OP_SW,  0, 7, 0, 3);
    run_prog(1'b1, 9, 0, "R3", "R10");
  endtask

  // R4: load into register 0 and readers of register 0
  task automatic t_reg_zero();
    p_n = 4;
    put(0, OP_LW,  1, 0, 0, 0);
    put(1, OP_ADD, 0, 0, 8, 0);
    put(2, OP_ADD, 2, 2, 0, 0);
    put(3, OP_OR,  0, 3, 9, 0);
    run_prog(1'b1, 8, 0, "R4", "R4");
  endtask

  // R5 R6 R12: load feeding the second operand, store needing write-through
  task automatic t_load_second_operand();
    p_n = 3;
    put(0, OP_LW,  0, 4, 0, 2);
    put(1, OP_ADD, 1, 4, 5, 0);
    put(2, OP_SW,  4, 5, 0, 0);
    run_prog(1'b1, 8, 1, "R6", "R12");
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fwd_en = 1'b1;
    drive_idle();
    t_reset_state();
    t_sub_chain_fwd();
    t_sub_chain_nofwd();
    t_load_chain();
    t_priority_store();
    t_reg_zero();
    t_load_second_operand();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule